// File: doc/BRIEF.md
# Slave Data Register with No-Stretch Overrun Guard

This block holds the single data register of a byte-serial bus slave whose clock stretching is turned off. Because such a slave cannot hold the clock low to wait for software, two things can go wrong:

- A received byte can arrive while the previous byte is still unread.
- The shifter can ask for the next outgoing byte before software has written one.

The block handles both cases. It keeps the unread byte and drops the arriving one, or it hands the shifter the byte it sent last time. In either case it raises a sticky error flag.

The shift logic reports two kinds of event. It reports a completed received byte, counted after its acknowledge bit, and it requests the next transmit byte. The CPU side supplies read and write strobes for the data register, a clear strobe for the flag, and the control inputs (role, no-stretch mode, peripheral enable). An internal occupancy bit records whether the register holds a byte that has not yet been consumed. Reset is asserted asynchronously (active low) and released synchronously inside the block.

Top module: `slv_dbuf_guard`

## Requirements
- R1: While reset is applied and after its release, the data register, the transmit byte and the error flag all read zero.
- R2: Overrun and underrun are detected only when `slave_i`=1 and `no_stretch_i`=1. In any other mode a received byte always overwrites the register, and a transmit request on an empty register keeps the transmit byte without raising the flag.
- R3: In detection mode, a completed received byte that arrives while the register still holds an unread byte sets the error flag.
- R4: In that overrun case, the arriving byte is discarded and the register keeps its previous contents.
- R5: In detection mode, a transmit request that finds the register empty sets the error flag and leaves the transmit byte unchanged, so the previous byte is sent again.
- R6: A CPU read in the same cycle as a completed byte frees the register first, so the new byte is stored without an error. A CPU write in the same cycle as a transmit request counts as written, and the written byte goes straight to the shifter.
- R7: The flag stays set until `flag_clr_i` is pulsed. If a new error and the clear fall in the same cycle, the flag ends set.
- R8: While `enable_i`=0, the flag and the occupancy bit are cleared, and all events leave the data register and the transmit byte unchanged.
- R9: A received byte on an empty register is stored and marks the register full. A CPU write stores its data and marks the register full. A CPU read marks it empty. A transmit request on a full register hands its byte to the shifter and marks it empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Peripheral enable |
| slave_i | input | 1 | Role is slave |
| no_stretch_i | input | 1 | Clock stretching disabled |
| rx_done_i | input | 1 | Received byte complete, acknowledge bit included |
| rx_byte_i | input | W | Byte delivered by the shifter |
| tx_req_i | input | 1 | Shifter requests the next byte to send |
| cpu_rd_i | input | 1 | CPU reads the data register |
| cpu_wr_i | input | 1 | CPU writes the data register |
| cpu_wdata_i | input | W | CPU write data |
| flag_clr_i | input | 1 | Software clears the error flag |
| dreg_o | output | W | Data register contents |
| tx_byte_o | output | W | Byte handed to the transmit shifter |
| xrun_o | output | 1 | Sticky overrun/underrun flag |

## Verification
Two pairs of functions can collide in one cycle, and the bench drives each collision on purpose.

The first pair is a CPU access against a shifter event. A read is issued on the same cycle as a completed byte while the register is full, and a write is issued on the same cycle as a transmit request while the register is both full and empty. The bench checks that the read avoids the overrun and stores the new byte. It also checks that the write's data reaches the transmit byte with no flag, whatever the register held.

The second pair is an error against a software clear on the same cycle. The bench checks that the flag ends set.

// File: rtl/slv_dbuf_pkg.sv
package slv_dbuf_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic rx_done;
    logic tx_req;
    logic cpu_rd;
    logic cpu_wr;
  } dbuf_ev_t;
endpackage

// File: rtl/slv_dbuf_rstsync.sv
module slv_dbuf_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/slv_dbuf_store.sv
module slv_dbuf_store
  import slv_dbuf_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         det,
  input  dbuf_ev_t     ev,
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dreg,
  output logic [W-1:0] tx_byte,
  output logic         full,
  output logic         err_evt
);
  logic [W-1:0] dreg_q, dreg_d, tx_q, tx_d, dat_a;
  logic         full_q, full_d, full_a, full_b, full_c;
  logic         rx_hit, tx_miss, ce;

  // next-state: read, then write, then receive, then transmit
  always_comb begin
    full_a  = full_q & ~ev.cpu_rd;
    dat_a   = ev.cpu_wr ? wdata : dreg_q;
    full_b  = full_a | ev.cpu_wr;
    rx_hit  = ev.rx_done & full_b & det;
    dreg_d  = dat_a;
    full_c  = full_b;
    if (ev.rx_done && !rx_hit) begin
      dreg_d = rx_byte;
      full_c = 1'b1;
    end
    tx_miss = ev.tx_req & ~full_c & det;
    tx_d    = tx_q;
    full_d  = full_c;
    if (ev.tx_req && full_c) begin
      tx_d   = dreg_d;
      full_d = 1'b0;
    end
    if (!en) begin
      dreg_d  = dreg_q;
      tx_d    = tx_q;
      full_d  = 1'b0;
      rx_hit  = 1'b0;
      tx_miss = 1'b0;
    end
    ce = en ? (|ev) : full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
      tx_q   <= '0;
      full_q <= 1'b0;
    end else if (ce) begin
      dreg_q <= dreg_d;
      tx_q   <= tx_d;
      full_q <= full_d;
    end
  end

  assign dreg    = dreg_q;
  assign tx_byte = tx_q;
  assign full    = full_q;
  assign err_evt = rx_hit | tx_miss;
endmodule

// File: rtl/slv_dbuf_flag.sv
module slv_dbuf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d, ce;

  always_comb begin
    ce = set | clr | ~en;
    if (!en)      flag_d = 1'b0;
    else if (set) flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag_q <= 1'b0;
    else if (ce) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/slv_dbuf_guard.sv
module slv_dbuf_guard
  import slv_dbuf_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable_i,
  input  logic         slave_i,
  input  logic         no_stretch_i,
  input  logic         rx_done_i,
  input  logic [W-1:0] rx_byte_i,
  input  logic         tx_req_i,
  input  logic         cpu_rd_i,
  input  logic         cpu_wr_i,
  input  logic [W-1:0] cpu_wdata_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] dreg_o,
  output logic [W-1:0] tx_byte_o,
  output logic         xrun_o
);
  logic     rst_sync_n;
  logic     det_w, full_w, err_w;
  dbuf_ev_t ev_w;

  assign det_w = slave_i & no_stretch_i;
  assign ev_w  = '{rx_done: rx_done_i, tx_req: tx_req_i,
                   cpu_rd: cpu_rd_i, cpu_wr: cpu_wr_i};

  slv_dbuf_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slv_dbuf_store #(.W(W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (enable_i),
    .det     (det_w),
    .ev      (ev_w),
    .rx_byte (rx_byte_i),
    .wdata   (cpu_wdata_i),
    .dreg    (dreg_o),
    .tx_byte (tx_byte_o),
    .full    (full_w),
    .err_evt (err_w)
  );

  slv_dbuf_flag u_flag (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (enable_i),
    .set   (err_w),
    .clr   (flag_clr_i),
    .flag  (xrun_o)
  );
endmodule

// File: rtl/slv_dbuf_guard_chk.sv
module slv_dbuf_guard_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable_i,
  input logic         slave_i,
  input logic         no_stretch_i,
  input logic         rx_done_i,
  input logic         tx_req_i,
  input logic         cpu_rd_i,
  input logic         cpu_wr_i,
  input logic         flag_clr_i,
  input logic         full,
  input logic [W-1:0] dreg_o,
  input logic [W-1:0] tx_byte_o,
  input logic         xrun_o
);
  logic det;
  assign det = slave_i & no_stretch_i;

  AST_RX_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && det && full && rx_done_i && !cpu_rd_i && !cpu_wr_i && !tx_req_i)
      |=> xrun_o); // R3

  AST_RX_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && det && full && rx_done_i && !cpu_rd_i && !cpu_wr_i && !tx_req_i)
      |=> $stable(dreg_o)); // R4

  AST_TX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && det && !full && tx_req_i && !cpu_wr_i && !rx_done_i)
      |=> (xrun_o && $stable(tx_byte_o))); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xrun_o && enable_i && !flag_clr_i) |=> xrun_o); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!xrun_o && !full)); // R8

  AST_NO_DETECT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrun_o && !det) |=> !xrun_o); // R2
endmodule

bind slv_dbuf_guard slv_dbuf_guard_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .enable_i     (enable_i),
  .slave_i      (slave_i),
  .no_stretch_i (no_stretch_i),
  .rx_done_i    (rx_done_i),
  .tx_req_i     (tx_req_i),
  .cpu_rd_i     (cpu_rd_i),
  .cpu_wr_i     (cpu_wr_i),
  .flag_clr_i   (flag_clr_i),
  .full         (full_w),
  .dreg_o       (dreg_o),
  .tx_byte_o    (tx_byte_o),
  .xrun_o       (xrun_o)
);

// File: tb/slv_dbuf_guard_bench.sv
module slv_dbuf_guard_bench;
  localparam int W = 8;
  localparam int NV = 19;

  logic         clk, rst_n, enable_i, slave_i, no_stretch_i;
  logic         rx_done_i, tx_req_i, cpu_rd_i, cpu_wr_i, flag_clr_i;
  logic [W-1:0] rx_byte_i, cpu_wdata_i, dreg_o, tx_byte_o;
  logic         xrun_o;
  int           total, bad;
  bit           done;

  slv_dbuf_guard #(.W(W)) u_slv_dbuf_guard (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .slave_i(slave_i),
    .no_stretch_i(no_stretch_i), .rx_done_i(rx_done_i), .rx_byte_i(rx_byte_i),
    .tx_req_i(tx_req_i), .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i),
    .cpu_wdata_i(cpu_wdata_i), .flag_clr_i(flag_clr_i), .dreg_o(dreg_o),
    .tx_byte_o(tx_byte_o), .xrun_o(xrun_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // control {slave, no_stretch, rx, tx, rd, wr, clr}, rx byte, write data,
  // expected dreg, expected tx byte, expected flag
  localparam logic [39:0] VEC [NV] = '{
    {7'b1110000, 8'hA1, 8'h00, 8'hA1, 8'h00, 1'b0}, // R9 store
    {7'b1110000, 8'hB2, 8'h00, 8'hA1, 8'h00, 1'b1}, // R3 R4 overrun
    {7'b1100100, 8'h00, 8'h00, 8'hA1, 8'h00, 1'b1}, // R7 sticky over read
    {7'b1100001, 8'h00, 8'h00, 8'hA1, 8'h00, 1'b0}, // R7 clear
    {7'b1110000, 8'hC3, 8'h00, 8'hC3, 8'h00, 1'b0}, // R9
    {7'b1110100, 8'hD4, 8'h00, 8'hD4, 8'h00, 1'b0}, // R6 read+rx
    {7'b1100100, 8'h00, 8'h00, 8'hD4, 8'h00, 1'b0}, // R9 read
    {7'b1100010, 8'h00, 8'h5A, 8'h5A, 8'h00, 1'b0}, // R9 write
    {7'b1101000, 8'h00, 8'h00, 8'h5A, 8'h5A, 1'b0}, // R9 tx handoff
    {7'b1101000, 8'h00, 8'h00, 8'h5A, 8'h5A, 1'b1}, // R5 underrun
    {7'b1100011, 8'h00, 8'h6B, 8'h6B, 8'h5A, 1'b0}, // R7 clear with write
    {7'b1101010, 8'h00, 8'h7C, 8'h7C, 8'h7C, 1'b0}, // R6 write+tx full
    {7'b1101010, 8'h00, 8'h8D, 8'h8D, 8'h8D, 1'b0}, // R6 write+tx empty
    {7'b1001000, 8'h00, 8'h00, 8'h8D, 8'h8D, 1'b0}, // R2 stretch mode tx
    {7'b1010000, 8'hE5, 8'h00, 8'hE5, 8'h8D, 1'b0}, // R2
    {7'b1010000, 8'hF6, 8'h00, 8'hF6, 8'h8D, 1'b0}, // R2 overwrite
    {7'b0110000, 8'h17, 8'h00, 8'h17, 8'h8D, 1'b0}, // R2 master overwrite
    {7'b1101000, 8'h00, 8'h00, 8'h17, 8'h17, 1'b0}, // R9
    {7'b1101001, 8'h00, 8'h00, 8'h17, 8'h17, 1'b1}  // R7 set beats clear
  };

  task automatic check(input string req, input logic [W-1:0] ed,
                       input logic [W-1:0] et, input logic ef);
    total++;
    if (dreg_o !== ed || tx_byte_o !== et || xrun_o !== ef) begin
      bad++;
      $display("FAIL %s: dreg=%h tx=%h flag=%b expected dreg=%h tx=%h flag=%b",
               req, dreg_o, tx_byte_o, xrun_o, ed, et, ef);
    end
  endtask

  task automatic idle();
    rx_done_i = 0; tx_req_i = 0; cpu_rd_i = 0; cpu_wr_i = 0; flag_clr_i = 0;
    rx_byte_i = '0; cpu_wdata_i = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 0; enable_i = 1; slave_i = 1; no_stretch_i = 1;
    idle();
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h00, 8'h00, 1'b0);
    rst_n = 1;
    repeat (3) step();
    check("R1 after release", 8'h00, 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {slave_i, no_stretch_i, rx_done_i, tx_req_i, cpu_rd_i, cpu_wr_i,
       flag_clr_i} = VEC[i][39:33];
      rx_byte_i   = VEC[i][32:25];
      cpu_wdata_i = VEC[i][24:17];
      step();
      idle();
      check($sformatf("R2-9 vector %0d", i), VEC[i][16:9], VEC[i][8:1],
            VEC[i][0]);
    end

    // R8: disable clears flag and occupancy, events ignored
    slave_i = 1; no_stretch_i = 1;
    enable_i = 0;
    rx_done_i = 1; rx_byte_i = 8'h55; cpu_wr_i = 1; cpu_wdata_i = 8'h66;
    step();
    idle();
    check("R8 disabled", 8'h17, 8'h17, 1'b0);
    tx_req_i = 1;
    step();
    idle();
    check("R8 tx ignored", 8'h17, 8'h17, 1'b0);
    enable_i = 1;
    rx_done_i = 1; rx_byte_i = 8'h99;
    step();
    idle();
    check("R8 occupancy cleared", 8'h99, 8'h17, 1'b0);

    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk);
    check("R1 mid-run reset", 8'h00, 8'h00, 1'b0);
    rst_n = 1;
    repeat (3) step();
    tx_req_i = 1;
    step();
    idle();
    check("R5 underrun after reset", 8'h00, 8'h00, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule